// File: doc/BRIEF.md
# Four-Slot Event Timestamp Sequencer

This block stamps the moments at which an external signal changes. A 32-bit time-base counter runs on the block clock. The event pin is first synchronised, then optionally divided by an even ratio. The resulting edges are steered into four capture slots, one after another, under a rotating sequence pointer. Each slot chooses its own edge direction. Each slot can also clear the counter right after it has stored its stamp. With the clear turned off, a slot holds absolute time. With it on, the slot holds the time since the previous clearing event.

Two sequencing modes are available. In continuous mode the pointer cycles through the slots without end. In single-pass mode the sequence halts after a programmed slot and stays halted until a re-arm command. A small write port sets up the control word, preloads the counter and can overwrite any slot. The block drives a one-cycle pulse per slot event and a one-cycle wrap pulse, which an interrupt controller next to it consumes.

The sequencer has two named states. In SEQ_ARMED it accepts events and advances the pointer. In SEQ_FROZEN it ignores all events and holds the pointer. There are four transitions. SEQ_ARMED to SEQ_ARMED on an accepted event advances the pointer, or wraps it from the last slot to slot 0. SEQ_ARMED to SEQ_FROZEN happens on an accepted event in single-pass mode when the pointer equals the stop slot. SEQ_FROZEN to SEQ_ARMED happens on re-arm. SEQ_ARMED to SEQ_ARMED on re-arm clears the pointer to 0.

Top module: `evt_stamp_seq`

## Requirements
- R1: After reset the counter, all four slots and the pointer read 0, the block is not halted, no pulse is driven, and the control word holds stop slot 3 with every other field 0.
- R2: Address 1 loads the counter with the written value. Control bit 0 (run) freezes the counter when 0. When it is 1 the counter adds one per clock.
- R3: When a running counter steps from all ones to 0, `ovf_o` is high for the one cycle in which `cnt_o` first reads 0.
- R4: Control bits 14..11 pick the edge for slots 3..0: 0 selects a rising edge and 1 a falling edge. In bypass, a pin change applied between clock edges is acted on at the third rising clock edge after it. That edge stores the counter value present just before it.
- R5: With control bit 2 (single-pass) at 0, accepted events go to slots 0,1,2,3,0,... in turn, whatever the stop slot.
- R6: Control bits 18..15 enable the counter clear for slots 3..0. A slot with its clear bit set stores the pre-clear counter value, and the counter reads 0 right after that edge.
- R7: With single-pass set, the event taken while the pointer equals the stop slot (control bits 5..4) sets `seq_halted_o`. From then on no event is taken, no pulse is driven and the pointer holds.
- R8: Writing the control word with bit 3 (re-arm) set clears the pointer to 0 and leaves the halted state, in both modes. The bit is a command and is not stored.
- R9: Control bit 1 (load enable) gates slot loads. While it is 0, events still pulse and advance the pointer, but every slot keeps its value.
- R10: Control bits 10..6 set a prescale code N. Code 0 passes the synchronised pin straight through. Code N>0 toggles an internal signal every N rising pin edges, which divides the pin by 2N. The slots then see the edges of that internal signal.
- R11: Addresses 2 to 5 overwrite slots 0 to 3 with the written value.
- R12: An accepted event drives a one-hot pulse on `slot_evt_o`, naming the slot it used, in the cycle after the capture edge. The pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 3 | 0 control word, 1 counter, 2..5 slots 0..3 |
| cfg_wdata | input | 32 | Write data |
| evt_in | input | 1 | Asynchronous event pin |
| cnt_o | output | 32 | Time-base counter value |
| caps_o | output | 128 | Slot k stored stamp on bits 32k+31..32k |
| slot_evt_o | output | 4 | One-cycle pulse per accepted slot event |
| ovf_o | output | 1 | One-cycle counter wrap pulse |
| seq_ptr_o | output | 2 | Slot that will take the next event |
| seq_halted_o | output | 1 | Sequencer is in SEQ_FROZEN |

## Verification
The bound assertions watch, on every cycle, that pulses stay one-hot and match the slot the pointer named one cycle earlier. They also check that a halted sequencer drives no pulse and either holds its pointer or leaves with it at 0. They check that slots change only after an event or a write, and that a wrap pulse coincides with a zero count. Some behaviour can only be shown by the bench's scenarios, because it depends on control fields that do not appear at the ports. This covers the exact stamp values, the edge direction per slot, the counter clear in difference timing, load gating, the stop slot of single-pass mode and the event counts produced by each prescale ratio.

// File: rtl/evt_seq_pkg.sv
package evt_seq_pkg;

    // Sequencer states
    typedef enum logic [0:0] {
        SEQ_ARMED  = 1'b0,
        SEQ_FROZEN = 1'b1
    } seq_state_e;

    // Write-port address map
    localparam int unsigned ADDR_CTRL  = 0;
    localparam int unsigned ADDR_TIME  = 1;
    localparam int unsigned ADDR_SLOT0 = 2;

    // Fixed low control bits; the wider fields follow from module parameters
    localparam int unsigned CB_RUN     = 0;
    localparam int unsigned CB_LDEN    = 1;
    localparam int unsigned CB_ONESHOT = 2;
    localparam int unsigned CB_REARM   = 3;
    localparam int unsigned CB_STOP    = 4;

endpackage

// File: rtl/evt_timebase.sv
module evt_timebase #(
    parameter int unsigned TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          ld,
    input  logic [TW-1:0] ld_val,
    input  logic          clr,
    output logic [TW-1:0] cnt_o,
    output logic          ovf_o
);

    logic [TW-1:0] cnt_q;
    logic          ovf_q;
    logic          at_top;

    assign at_top = (cnt_q == {TW{1'b1}});

    // Priority: software load, then slot clear, then counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld) begin
            cnt_q <= ld_val;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Wrap pulse only for a natural increment past all ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= !ld && !clr && run && at_top;
        end
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

endmodule

// File: rtl/evt_sync_presc.sv
module evt_sync_presc #(
    parameter int unsigned PSW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           evt_in,
    input  logic [PSW-1:0] code,
    output logic           ev_rise,
    output logic           ev_fall
);

    logic           s1_q, s2_q, s2_d_q;
    logic [PSW-1:0] pcnt_q;
    logic           div_q;
    logic           pre;
    logic           pre_d_q;
    logic           bypass;
    logic           pin_rise;

    assign bypass   = (code == '0);
    assign pin_rise = s2_q && !s2_d_q;

    // Two-flop synchroniser plus one delay stage for pin edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            s2_d_q <= 1'b0;
        end else begin
            s1_q   <= evt_in;
            s2_q   <= s1_q;
            s2_d_q <= s2_q;
        end
    end

    // Even divider: toggle after every 'code' rising pin edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            div_q  <= 1'b0;
        end else if (bypass) begin
            pcnt_q <= '0;
            div_q  <= 1'b0;
        end else if (pin_rise) begin
            if (pcnt_q >= code - PSW'(1)) begin
                pcnt_q <= '0;
                div_q  <= !div_q;
            end else begin
                pcnt_q <= pcnt_q + PSW'(1);
            end
        end
    end

    assign pre = bypass ? s2_q : div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_d_q <= 1'b0;
        end else begin
            pre_d_q <= pre;
        end
    end

    assign ev_rise = pre && !pre_d_q;
    assign ev_fall = !pre && pre_d_q;

endmodule

// File: rtl/evt_seq_fsm.sv
module evt_seq_fsm
    import evt_seq_pkg::*;
#(
    parameter  int unsigned NSLOT = 4,
    localparam int unsigned PTRW  = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_rise,
    input  logic             ev_fall,
    input  logic [NSLOT-1:0] pol,
    input  logic             oneshot,
    input  logic [PTRW-1:0]  stop_val,
    input  logic             rearm,
    output logic             take_o,
    output logic [NSLOT-1:0] take_oh_o,
    output logic [PTRW-1:0]  ptr_o,
    output logic             halted_o
);

    localparam logic [PTRW-1:0]  LAST_SLOT = PTRW'(NSLOT - 1);
    localparam logic [NSLOT-1:0] ONE_HOT0  = {{(NSLOT-1){1'b0}}, 1'b1};

    seq_state_e      state_q, state_d;
    logic [PTRW-1:0] ptr_q, ptr_d;
    logic            edge_sel;
    logic            take;

    assign edge_sel = pol[ptr_q] ? ev_fall : ev_rise;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_ARMED;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // Next-state logic; re-arm wins over a coincident event
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            SEQ_ARMED: begin
                if (rearm) begin
                    ptr_d = '0;
                end else if (take) begin
                    if (oneshot && (ptr_q == stop_val)) begin
                        state_d = SEQ_FROZEN;
                    end else if (ptr_q == LAST_SLOT) begin
                        ptr_d = '0;
                    end else begin
                        ptr_d = ptr_q + PTRW'(1);
                    end
                end
            end
            SEQ_FROZEN: begin
                if (rearm) begin
                    state_d = SEQ_ARMED;
                    ptr_d   = '0;
                end
            end
            default: begin
                state_d = SEQ_ARMED;
                ptr_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        take      = (state_q == SEQ_ARMED) && edge_sel && !rearm;
        take_oh_o = take ? (ONE_HOT0 << ptr_q) : '0;
        take_o    = take;
        ptr_o     = ptr_q;
        halted_o  = (state_q == SEQ_FROZEN);
    end

endmodule

// File: rtl/evt_stamp_seq.sv
module evt_stamp_seq
    import evt_seq_pkg::*;
#(
    parameter  int unsigned TW    = 32,
    parameter  int unsigned NSLOT = 4,
    parameter  int unsigned PSW   = 5,
    localparam int unsigned PTRW  = $clog2(NSLOT),
    localparam int unsigned AW    = $clog2(NSLOT + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [AW-1:0]       cfg_addr,
    input  logic [TW-1:0]       cfg_wdata,
    input  logic                evt_in,
    output logic [TW-1:0]       cnt_o,
    output logic [NSLOT*TW-1:0] caps_o,
    output logic [NSLOT-1:0]    slot_evt_o,
    output logic                ovf_o,
    output logic [PTRW-1:0]     seq_ptr_o,
    output logic                seq_halted_o
);

    // Control word layout derived from the parameters
    localparam int unsigned POS_PSC = CB_STOP + PTRW;
    localparam int unsigned POS_POL = POS_PSC + PSW;
    localparam int unsigned POS_RST = POS_POL + NSLOT;
    localparam int unsigned CTRL_W  = POS_RST + NSLOT;

    logic             run_q, lden_q, oneshot_q;
    logic [PTRW-1:0]  stop_q;
    logic [PSW-1:0]   psc_q;
    logic [NSLOT-1:0] pol_q, rst_q;

    logic             wr_ctrl, wr_time, rearm;
    logic             ev_rise, ev_fall;
    logic             take;
    logic [NSLOT-1:0] take_oh;
    logic             cnt_clr;
    logic [NSLOT-1:0] slot_evt_q;

    assign wr_ctrl = cfg_we && (cfg_addr == AW'(ADDR_CTRL));
    assign wr_time = cfg_we && (cfg_addr == AW'(ADDR_TIME));
    assign rearm   = wr_ctrl && cfg_wdata[CB_REARM];

    // Control register; the re-arm bit is a command and is not kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            lden_q    <= 1'b0;
            oneshot_q <= 1'b0;
            stop_q    <= '1;
            psc_q     <= '0;
            pol_q     <= '0;
            rst_q     <= '0;
        end else if (wr_ctrl) begin
            run_q     <= cfg_wdata[CB_RUN];
            lden_q    <= cfg_wdata[CB_LDEN];
            oneshot_q <= cfg_wdata[CB_ONESHOT];
            stop_q    <= cfg_wdata[CB_STOP +: PTRW];
            psc_q     <= cfg_wdata[POS_PSC +: PSW];
            pol_q     <= cfg_wdata[POS_POL +: NSLOT];
            rst_q     <= cfg_wdata[POS_RST +: NSLOT];
        end
    end

    evt_sync_presc #(.PSW(PSW)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_in  (evt_in),
        .code    (psc_q),
        .ev_rise (ev_rise),
        .ev_fall (ev_fall)
    );

    evt_seq_fsm #(.NSLOT(NSLOT)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_rise   (ev_rise),
        .ev_fall   (ev_fall),
        .pol       (pol_q),
        .oneshot   (oneshot_q),
        .stop_val  (stop_q),
        .rearm     (rearm),
        .take_o    (take),
        .take_oh_o (take_oh),
        .ptr_o     (seq_ptr_o),
        .halted_o  (seq_halted_o)
    );

    assign cnt_clr = take && |(take_oh & rst_q);

    evt_timebase #(.TW(TW)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .ld     (wr_time),
        .ld_val (cfg_wdata),
        .clr    (cnt_clr),
        .cnt_o  (cnt_o),
        .ovf_o  (ovf_o)
    );

    // Capture slots; an event load wins over a software write
    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        logic [TW-1:0] cap_q;
        logic          sw_wr;

        assign sw_wr = cfg_we && (cfg_addr == AW'(ADDR_SLOT0 + k));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cap_q <= '0;
            end else if (take_oh[k] && lden_q) begin
                cap_q <= cnt_o;
            end else if (sw_wr) begin
                cap_q <= cfg_wdata;
            end
        end

        assign caps_o[k*TW +: TW] = cap_q;
    end

    // Per-slot event pulse, one cycle after the capture edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_evt_q <= '0;
        end else begin
            slot_evt_q <= take_oh;
        end
    end

    assign slot_evt_o = slot_evt_q;

    initial begin
        if (CTRL_W > TW) $error("control word does not fit the data width");
    end

endmodule

// File: rtl/evt_stamp_seq_chk.sv
module evt_stamp_seq_chk #(
    parameter  int unsigned TW    = 32,
    parameter  int unsigned NSLOT = 4,
    localparam int unsigned PTRW  = $clog2(NSLOT)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_we,
    input logic [TW-1:0]       cnt_o,
    input logic [NSLOT*TW-1:0] caps_o,
    input logic [NSLOT-1:0]    slot_evt_o,
    input logic                ovf_o,
    input logic [PTRW-1:0]     seq_ptr_o,
    input logic                seq_halted_o
);

    localparam logic [NSLOT-1:0] ONE_HOT0 = {{(NSLOT-1){1'b0}}, 1'b1};

    AST_SLOT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_evt_o)); // R12

    AST_SLOT_MATCHES_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_evt_o) |-> (slot_evt_o == (ONE_HOT0 << $past(seq_ptr_o)))); // R5

    AST_HALTED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        seq_halted_o |=> (slot_evt_o == '0)); // R7

    AST_HALTED_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        seq_halted_o |=> (seq_halted_o ? $stable(seq_ptr_o) : (seq_ptr_o == '0))); // R8

    AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (cnt_o == '0)); // R3

    AST_SLOTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_evt_o == '0) && !$past(cfg_we)) |-> $stable(caps_o)); // R11

endmodule

bind evt_stamp_seq evt_stamp_seq_chk #(.TW(TW), .NSLOT(NSLOT)) u_chk (.*);

// File: tb/tb_evt_stamp_seq.sv
`timescale 1ns/1ps
module tb_evt_stamp_seq;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_addr = '0;
    logic [31:0]  cfg_wdata = '0;
    logic         evt_in = 1'b0;
    logic [31:0]  cnt_o;
    logic [127:0] caps_o;
    logic [3:0]   slot_evt_o;
    logic         ovf_o;
    logic [1:0]   seq_ptr_o;
    logic         seq_halted_o;

    always #2.5 clk = ~clk;

    evt_stamp_seq dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .evt_in       (evt_in),
        .cnt_o        (cnt_o),
        .caps_o       (caps_o),
        .slot_evt_o   (slot_evt_o),
        .ovf_o        (ovf_o),
        .seq_ptr_o    (seq_ptr_o),
        .seq_halted_o (seq_halted_o)
    );

    int n_vec = 0;
    int n_bad = 0;
    int ev_total = 0;

    // Shadow of the control fields
    bit       b_run, b_lden, b_one;
    bit [1:0] b_stop = 2'd3;
    bit [4:0] b_psc;
    bit [3:0] b_pol, b_rst;

    // Model of the sequencer
    int          m_ptr = 0;
    bit          m_halt = 1'b0;
    logic [31:0] m_cap [4] = '{default: '0};

    always @(negedge clk) if (rst_n && (slot_evt_o != 4'b0)) ev_total++;

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ctrl_word(bit rearm);
        logic [31:0] w = '0;
        w[0] = b_run;  w[1] = b_lden; w[2] = b_one; w[3] = rearm;
        w[5:4] = b_stop; w[10:6] = b_psc; w[14:11] = b_pol; w[18:15] = b_rst;
        return w;
    endfunction

    function automatic int presc_events(int rises, int code);
        if (code == 0) return rises;
        return (rises / code + 1) / 2;
    endfunction

    task automatic cfg_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_ctrl(bit rearm);
        cfg_write(3'd0, ctrl_word(rearm));
        if (rearm) begin
            m_ptr = 0;
            m_halt = 1'b0;
        end
    endtask

    task automatic check_caps(string tag);
        for (int k = 0; k < 4; k++)
            check({tag, " slot value"}, caps_o[k*32 +: 32], m_cap[k]);
    endtask

    // Toggle the pin once (bypass mode) and check the full response
    task automatic edge_step(string tag);
        logic        lvl;
        logic [31:0] pre;
        bit          exp_take;
        logic [3:0]  exp_oh;
        lvl = !evt_in;
        @(negedge clk) evt_in = lvl;
        @(posedge clk); @(posedge clk);
        @(negedge clk) pre = cnt_o;
        exp_take = !m_halt && (lvl ? !b_pol[m_ptr] : b_pol[m_ptr]);
        @(posedge clk);
        @(negedge clk);
        exp_oh = exp_take ? (4'b0001 << m_ptr) : 4'b0000;
        check({tag, " R12 pulse"}, {28'b0, slot_evt_o}, {28'b0, exp_oh});
        if (exp_take && b_lden) m_cap[m_ptr] = pre;
        check_caps(tag);
        check({tag, " counter"}, cnt_o,
              (exp_take && b_rst[m_ptr]) ? 32'd0 : pre + 32'd1);
        if (exp_take) begin
            if (b_one && (m_ptr == int'(b_stop))) m_halt = 1'b1;
            else m_ptr = (m_ptr + 1) % 4;
        end
        check({tag, " pointer"}, {30'b0, seq_ptr_o}, m_ptr);
        check({tag, " halted"}, {31'b0, seq_halted_o}, {31'b0, m_halt});
    endtask

    task automatic presc_run(int code, int rises);
        int base;
        b_psc = 5'd0; write_ctrl(1'b0);
        repeat (4) @(negedge clk);
        b_psc = 5'(code); write_ctrl(1'b0);
        base = ev_total;
        for (int i = 0; i < rises; i++) begin
            @(negedge clk) evt_in = 1'b1;
            repeat (3) @(negedge clk);
            evt_in = 1'b0;
            repeat (3) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        check("R10 prescaled event count", ev_total - base, presc_events(rises, code));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] a, b;
        int unsigned seed;
        seed = $urandom(32'd20240611);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 counter", cnt_o, 32'd0);
        check_caps("R1");
        check("R1 pointer", {30'b0, seq_ptr_o}, 32'd0);
        check("R1 halted", {31'b0, seq_halted_o}, 32'd0);
        check("R1 pulse", {28'b0, slot_evt_o}, 32'd0);
        check("R1 wrap", {31'b0, ovf_o}, 32'd0);

        // R2 load and freeze, then run
        cfg_write(3'd1, 32'd100);
        repeat (2) @(negedge clk);
        check("R2 frozen counter", cnt_o, 32'd100);
        b_run = 1'b1; write_ctrl(1'b0);
        @(negedge clk) a = cnt_o;
        @(negedge clk) b = cnt_o;
        check("R2 running counter", b, a + 32'd1);

        // R3 wrap pulse
        cfg_write(3'd1, 32'hFFFF_FFFC);
        for (int i = 0; i < 8; i++) begin
            if (cnt_o == 32'd0) begin
                check("R3 wrap pulse at zero", {31'b0, ovf_o}, 32'd1);
                break;
            end
            check("R3 no wrap pulse", {31'b0, ovf_o}, 32'd0);
            @(negedge clk);
        end
        @(negedge clk);
        check("R3 pulse lasts one cycle", {31'b0, ovf_o}, 32'd0);

        // R5 continuous rotation, stop slot ignored
        b_lden = 1'b1; b_one = 1'b0; b_stop = 2'd0; b_pol = 4'b0; b_rst = 4'b0;
        write_ctrl(1'b1);
        for (int i = 0; i < 20; i++) edge_step("R5");

        // R4 mixed polarities
        b_pol = 4'b1010; write_ctrl(1'b1);
        for (int i = 0; i < 16; i++) edge_step("R4");

        // R6 difference timing
        b_pol = 4'b0000; b_rst = 4'b1111; write_ctrl(1'b1);
        for (int i = 0; i < 12; i++) edge_step("R6");
        b_rst = 4'b0100; write_ctrl(1'b0);
        for (int i = 0; i < 10; i++) edge_step("R6");

        // R7 single-pass stop after the second slot
        b_rst = 4'b0; b_one = 1'b1; b_stop = 2'd1; write_ctrl(1'b1);
        for (int i = 0; i < 12; i++) edge_step("R7");
        check("R7 halted after stop slot", {31'b0, seq_halted_o}, 32'd1);

        // R8 re-arm in both modes
        write_ctrl(1'b1);
        check("R8 pointer cleared", {30'b0, seq_ptr_o}, 32'd0);
        check("R8 halt left", {31'b0, seq_halted_o}, 32'd0);
        for (int i = 0; i < 6; i++) edge_step("R8");
        b_one = 1'b0; write_ctrl(1'b0);
        for (int i = 0; i < 4; i++) edge_step("R8");
        write_ctrl(1'b1);
        check("R8 continuous re-arm", {30'b0, seq_ptr_o}, 32'd0);

        // R9 load gating
        b_lden = 1'b0; write_ctrl(1'b0);
        for (int i = 0; i < 10; i++) edge_step("R9");

        // R11 software slot writes
        cfg_write(3'd4, 32'hA5A5_0F0F); m_cap[2] = 32'hA5A5_0F0F;
        cfg_write(3'd5, 32'h1234_5678); m_cap[3] = 32'h1234_5678;
        check_caps("R11");

        // R10 prescaler ratios (loads gated so slots stay put)
        if (evt_in) edge_step("R10");
        presc_run(0, 5);
        presc_run(1, 6);
        presc_run(3, 13);
        presc_run(31, 70);
        b_psc = 5'd0; write_ctrl(1'b1);
        repeat (4) @(negedge clk);
        check_caps("R10 slots untouched");

        // Random phase
        b_lden = 1'b1; write_ctrl(1'b1);
        for (int blk = 0; blk < 14; blk++) begin
            b_pol  = 4'($urandom);
            b_rst  = 4'($urandom);
            b_lden = ($urandom % 4) != 0;
            b_one  = 1'($urandom);
            b_stop = 2'($urandom);
            write_ctrl(($urandom % 3) == 0);
            if (($urandom % 2) == 0) begin
                int s = $urandom % 4;
                logic [31:0] d = $urandom;
                cfg_write(3'(2 + s), d);
                m_cap[s] = d;
            end
            if (($urandom % 4) == 0) cfg_write(3'd1, $urandom);
            for (int i = 0; i < 12; i++) begin
                edge_step(b_one ? "R7 random" : "R5 random");
                repeat ($urandom % 4) @(negedge clk);
            end
        end

        finish_run();
    end

endmodule